// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Bridge

This block lets synchronous on-chip logic use an external asynchronous static RAM of 16-bit words addressed by 16 bits. A requester offers one access at a time on a valid/ready handshake: a write flag, an address, write data and two active-high byte-lane enables. The bridge latches the request, then plays out the matching strobe sequence on the memory pins (active-low chip select, write strobe, output strobe and one strobe per byte lane) with every phase length counted in clock cycles. The cycle counts are derived from nanosecond limits given as parameters against the clock period. Read data comes back on a registered port with a one-cycle valid strobe.

The shared data pins are split into an output value, an input value and a drive-enable, so the pad ring can place its tristate cell outside the block. The bridge never drives the pins while the memory's outputs are on: the drive-enable and the output strobe are never active together, and a write that follows a read waits out a release window first.

States: `ST_IDLE` (ready, all strobes inactive), `ST_TURN` (release window before a write that follows a read), `ST_WR_SETUP` (address, lanes and data presented, write strobe high), `ST_WR_PULSE` (write strobe low), `ST_WR_HOLD` (write strobe back high, data still driven), `ST_RD_ACCESS` (chip select and output strobe low). Transitions: IDLE to IDLE on a request with no lane enabled; IDLE to RD_ACCESS on a read; IDLE to TURN on a write when a read has completed since the last write, otherwise IDLE to WR_SETUP; TURN to WR_SETUP, WR_SETUP to WR_PULSE and RD_ACCESS to IDLE when their cycle count expires; WR_PULSE to WR_HOLD on expiry; WR_HOLD to IDLE always.

Top module: `sram_lane_bridge`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, chip select, write strobe, output strobe and both lane strobes are high (inactive), `mem_dq_oe` is 0 and `rsp_valid` is 0 after reset.
- R2: A write with at least one lane enabled shows, in order: SETUP_CYC cycles (default 1) with chip select low, write strobe high and the bus driven; WE_CYC cycles (default 1, from ceil(8 ns / period)) with the write strobe low; one cycle with the write strobe high and the bus still driven. Address and write data stay constant throughout.
- R3: `req_be[0]` maps to `mem_lb_n` and data bits 7:0; `req_be[1]` maps to `mem_ub_n` and bits 15:8; a lane strobe is low during an access only when its enable was 1; both set gives a 16-bit access.
- R4: A read drives chip select and output strobe low with the write strobe high for RD_CYC cycles (default 2, from ceil(12 ns / period)), samples `mem_dq_in` at the clock edge ending the last of them, and raises `rsp_valid` for exactly one cycle, the cycle after.
- R5: In `rsp_rdata`, byte lanes whose enable was 0 read as 0x00; enabled lanes carry the sampled pin value.
- R6: `mem_dq_oe` is never 1 in a cycle where `mem_oe_n` is 0.
- R7: A write accepted right after a read's response cycle starts driving the bus after exactly 1 + TURN_CYC cycles (default TURN_CYC = 1) of output strobe high following the last output-strobe-low cycle.
- R8: A request with both lane enables 0 is accepted without any chip-select-low cycle; a write of that kind changes no memory contents, and a read of that kind returns `rsp_valid` in the next cycle with `rsp_rdata` = 0x0000.
- R9: `req_ready` is low from the cycle after a memory access is accepted until that access has finished; at most one request is taken per handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bridge idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = low byte, bit 1 = high byte |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 16 | Memory address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_lb_n | output | 1 | Low byte lane strobe, active low |
| mem_ub_n | output | 1 | High byte lane strobe, active low |
| mem_dq_out | output | 16 | Value to drive on the data pins |
| mem_dq_oe | output | 1 | Drive-enable for the data pins |
| mem_dq_in | input | 16 | Value seen on the data pins |

## Verification
The response strobe of a finished read and the acceptance of the next request fall in the same idle cycle, and when that request is a write the bridge must both deliver the read word and decide on the release window in that cycle. The bench provokes it by holding a write on the request port in the very cycle `rsp_valid` is seen high, then judges that the read word matches the memory model and that the gap between the last output-strobe-low cycle and the first drive-enable cycle equals 1 + TURN_CYC. The memory model only presents valid data after the output strobe has been low for RD_CYC cycles, so an early sample is caught as a wrong word.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_ACCESS
    } bridge_state_e;

    // Round a time in ns up to whole clock cycles, never below one.
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int r;
        r = (ns + period_ns - 1) / period_ns;
        return (r < 1) ? 1 : r;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_bridge_timer.sv
module sram_bridge_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_bridge_fsm.sv
module sram_bridge_fsm
    import sram_bridge_pkg::*;
#(
    parameter int CNT_W     = 2,
    parameter int SETUP_CYC = 1,
    parameter int WE_CYC    = 1,
    parameter int RD_CYC    = 2,
    parameter int TURN_CYC  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_none,
    input  logic             timer_done,
    output bridge_state_e    state_q,
    output logic             accept,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             read_done,
    output logic             zero_read
);

    bridge_state_e state_d;
    logic          rd_recent_q;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign read_done = (state_q == ST_RD_ACCESS) && timer_done;
    assign zero_read = accept && !req_write && req_none;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !req_none) begin
                    if (!req_write) state_d = ST_RD_ACCESS;
                    else if (rd_recent_q) state_d = ST_TURN;
                    else state_d = ST_WR_SETUP;
                end
            end
            ST_TURN:      if (timer_done) state_d = ST_WR_SETUP;
            ST_WR_SETUP:  if (timer_done) state_d = ST_WR_PULSE;
            ST_WR_PULSE:  if (timer_done) state_d = ST_WR_HOLD;
            ST_WR_HOLD:   state_d = ST_IDLE;
            ST_RD_ACCESS: if (timer_done) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        timer_load = (state_d != state_q);
        unique case (state_d)
            ST_TURN:      timer_val = CNT_W'(TURN_CYC - 1);
            ST_WR_SETUP:  timer_val = CNT_W'(SETUP_CYC - 1);
            ST_WR_PULSE:  timer_val = CNT_W'(WE_CYC - 1);
            ST_RD_ACCESS: timer_val = CNT_W'(RD_CYC - 1);
            default:      timer_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_recent_q <= 1'b0;
        end else if (read_done) begin
            rd_recent_q <= 1'b1;
        end else if (state_d == ST_WR_SETUP) begin
            rd_recent_q <= 1'b0;
        end
    end

    // R9: once an access is taken, no request is accepted until idle again
    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_none) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/sram_bridge_lanes.sv
module sram_bridge_lanes #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    capture,
    input  logic                    zero_rsp,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic                    rsp_valid,
    output logic [LANES*LANE_W-1:0] rsp_rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= capture || zero_rsp;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rsp_rdata[g*LANE_W +: LANE_W] <= '0;
            end else if (capture && lane_en[g]) begin
                rsp_rdata[g*LANE_W +: LANE_W] <= dq_in[g*LANE_W +: LANE_W];
            end else if (capture || zero_rsp) begin
                rsp_rdata[g*LANE_W +: LANE_W] <= '0;
            end
        end
    end

    // R8: a lane-less read never coincides with a real capture
    assert_capture_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(capture && zero_rsp));

endmodule

// File: rtl/sram_lane_bridge.sv
module sram_lane_bridge
    import sram_bridge_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int LANE_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int WE_PULSE_NS   = 8,
    parameter int DATA_SETUP_NS = 6,
    parameter int READ_NS       = 12,
    parameter int RELEASE_NS    = 6,
    parameter int SETUP_CYC     = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*LANE_W-1:0] req_wdata,
    input  logic [1:0]          req_be,
    output logic                rsp_valid,
    output logic [2*LANE_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_ce_n,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic                mem_lb_n,
    output logic                mem_ub_n,
    output logic [2*LANE_W-1:0] mem_dq_out,
    output logic                mem_dq_oe,
    input  logic [2*LANE_W-1:0] mem_dq_in
);

    localparam int LANES    = 2;
    localparam int DATA_W   = LANES * LANE_W;
    localparam int WE_CYC   = ns_to_cycles(max2(WE_PULSE_NS, DATA_SETUP_NS), CLK_PERIOD_NS);
    localparam int RD_CYC   = ns_to_cycles(READ_NS, CLK_PERIOD_NS);
    localparam int TURN_CYC = ns_to_cycles(RELEASE_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC  = max2(max2(WE_CYC, RD_CYC), max2(TURN_CYC, SETUP_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC) + 1;

    bridge_state_e     state_q;
    logic              accept;
    logic              timer_load;
    logic [CNT_W-1:0]  timer_val;
    logic              timer_done;
    logic              read_done;
    logic              zero_read;
    logic              req_none;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic              lanes_on;

    assign req_none  = (req_be == '0);
    assign req_ready = (state_q == ST_IDLE);

    sram_bridge_fsm #(
        .CNT_W     (CNT_W),
        .SETUP_CYC (SETUP_CYC),
        .WE_CYC    (WE_CYC),
        .RD_CYC    (RD_CYC),
        .TURN_CYC  (TURN_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_none   (req_none),
        .timer_done (timer_done),
        .state_q    (state_q),
        .accept     (accept),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .read_done  (read_done),
        .zero_read  (zero_read)
    );

    sram_bridge_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .done     (timer_done)
    );

    sram_bridge_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (read_done),
        .zero_rsp  (zero_read),
        .lane_en   (be_q),
        .dq_in     (mem_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // Request capture: held unchanged for the whole access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    // Pin decode from the state register
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        lanes_on  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_TURN: ;
            ST_WR_SETUP, ST_WR_HOLD: begin
                mem_ce_n  = 1'b0;
                mem_dq_oe = 1'b1;
                lanes_on  = 1'b1;
            end
            ST_WR_PULSE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
                lanes_on  = 1'b1;
            end
            ST_RD_ACCESS: begin
                mem_ce_n  = 1'b0;
                mem_oe_n  = 1'b0;
                lanes_on  = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_lb_n   = ~(lanes_on & be_q[0]);
    assign mem_ub_n   = ~(lanes_on & be_q[1]);
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe));

    assert_we_fall_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_addr) && $stable(mem_dq_out)));

    assert_we_rise_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_addr) && $stable(mem_dq_out)));

    assert_write_has_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !(mem_lb_n && mem_ub_n));

    assert_read_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n && !mem_dq_oe));

    assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && !$past(mem_dq_oe)) |-> $past(mem_oe_n));

    assert_zero_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_none) |=> (req_ready && mem_ce_n));

endmodule

// File: tb/tb_sram_lane_bridge.sv
module tb_sram_lane_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int WE_CYC     = (8 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int RD_CYC     = (12 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int TURN_CYC   = (6 + CLK_PERIOD - 1) / CLK_PERIOD;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [15:0] data;
        logic [1:0]  be;
        logic [15:0] expect_rd;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 16'h0001, 16'h1234, 2'b11, 16'h0000},
        '{1'b0, 16'h0001, 16'h0000, 2'b11, 16'h1234},
        '{1'b1, 16'h0001, 16'h55CC, 2'b01, 16'h0000},
        '{1'b0, 16'h0001, 16'h0000, 2'b11, 16'h12CC},
        '{1'b1, 16'h0001, 16'h7788, 2'b10, 16'h0000},
        '{1'b0, 16'h0001, 16'h0000, 2'b11, 16'h77CC},
        '{1'b0, 16'h0001, 16'h0000, 2'b01, 16'h00CC},
        '{1'b0, 16'h0001, 16'h0000, 2'b10, 16'h7700},
        '{1'b1, 16'hFFFF, 16'hBEEF, 2'b11, 16'h0000},
        '{1'b0, 16'hFFFF, 16'h0000, 2'b11, 16'hBEEF},
        '{1'b1, 16'h0000, 16'h0F0F, 2'b11, 16'h0000},
        '{1'b0, 16'h0000, 16'h0000, 2'b11, 16'h0F0F},
        '{1'b0, 16'hFFFF, 16'h0000, 2'b11, 16'hBEEF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [15:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in = 16'hDEAD;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    sram_lane_bridge dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model and pin monitors, evaluated between clock edges
    logic [15:0] mem [logic [15:0]];
    int cyc = 0, ce_cycles = 0, contention = 0, last_oe_low = -100, last_gap = -1;
    int we_run = 0, we_len_bad = 0, we_pulses = 0, setup_bad = 0, oe_cnt = 0;
    bit dq_oe_prev = 1'b0, we_prev = 1'b1, setup_prev_ok = 1'b0;

    function automatic logic [15:0] mem_rd(input logic [15:0] a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    always @(negedge clk) begin
        logic [15:0] w, cur;
        cyc++;
        if (!mem_ce_n) ce_cycles++;
        if (mem_dq_oe && !mem_oe_n) contention++;
        if (!mem_oe_n) last_oe_low = cyc;
        if (mem_dq_oe && !dq_oe_prev) last_gap = cyc - last_oe_low - 1;
        dq_oe_prev = mem_dq_oe;
        if (!mem_we_n) begin
            if (we_prev && !setup_prev_ok) setup_bad++;
            we_run++;
        end else if (!we_prev) begin
            if (we_run != WE_CYC) we_len_bad++;
            we_pulses++;
            we_run = 0;
            if (!mem_ce_n) begin
                w   = mem_dq_oe ? mem_dq_out : 16'h0BAD;
                cur = mem_rd(mem_addr);
                if (!mem_lb_n) cur[7:0]  = w[7:0];
                if (!mem_ub_n) cur[15:8] = w[15:8];
                mem[mem_addr] = cur;
            end
        end
        setup_prev_ok = mem_dq_oe && !mem_ce_n && mem_we_n;
        we_prev = mem_we_n;
        if (!mem_ce_n && !mem_oe_n && mem_we_n) oe_cnt++;
        else oe_cnt = 0;
        if (oe_cnt >= RD_CYC) begin
            cur = mem_rd(mem_addr);
            mem_dq_in = {(!mem_ub_n ? cur[15:8] : 8'hA5), (!mem_lb_n ? cur[7:0] : 8'hA5)};
        end else begin
            mem_dq_in = 16'hDEAD;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one request from a falling edge; returns at a falling edge
    task automatic do_req(input logic wr, input logic [15:0] a, input logic [15:0] d,
                          input logic [1:0] be, output logic [15:0] rd);
        rd = '0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (!wr) begin
            while (!rsp_valid) @(negedge clk);
            rd = rsp_rdata;
        end else begin
            while (!req_ready) @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        int ce_before, pulses_before;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready, "R1 ready", 32'(req_ready), 1);
        chk({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'b11111, "R1 strobes",
            32'({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}), 32'h1F);
        chk(!mem_dq_oe && !rsp_valid, "R1 bus/rsp", 32'({mem_dq_oe, rsp_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_ce_n && !mem_dq_oe, "R1 idle", 32'({req_ready, mem_ce_n, mem_dq_oe}), 32'h6);

        // Table walk: R2 writes, R3 lane mapping, R4 reads, R5 masking
        for (int i = 0; i < NVEC; i++) begin
            do_req(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].be, rd);
            if (!VECS[i].wr) begin
                chk(rd == VECS[i].expect_rd, "R3/R4/R5 read data", 32'(rd), 32'(VECS[i].expect_rd));
                @(negedge clk);
                chk(!rsp_valid, "R4 single pulse", 32'(rsp_valid), 0);
            end
        end
        chk(we_len_bad == 0 && we_pulses == 5, "R2 pulse length", 32'(we_pulses), 5);
        chk(setup_bad == 0, "R2 setup before strobe", 32'(setup_bad), 0);

        // R9: busy after accept
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0001; req_be = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R9 busy", 32'(req_ready), 0);
        while (!rsp_valid) @(negedge clk);
        chk(rsp_rdata == 16'h77CC, "R4 read after busy", 32'(rsp_rdata), 32'h77CC);

        // R7: write offered in the read response cycle
        do_req(1'b0, 16'hFFFF, 16'h0, 2'b11, rd);
        do_req(1'b1, 16'h0002, 16'hA1B2, 2'b11, rd);
        chk(last_gap == 1 + TURN_CYC, "R7 turnaround gap", 32'(last_gap), 32'(1 + TURN_CYC));
        do_req(1'b0, 16'h0002, 16'h0, 2'b11, rd);
        chk(rd == 16'hA1B2, "R7 write after read data", 32'(rd), 32'hA1B2);

        // R8: no-lane requests
        ce_before = ce_cycles;
        pulses_before = we_pulses;
        do_req(1'b1, 16'h0002, 16'hFFFF, 2'b00, rd);
        @(negedge clk);
        chk(ce_cycles == ce_before && we_pulses == pulses_before, "R8 no-lane write",
            32'(ce_cycles - ce_before), 0);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0002; req_be = 2'b00;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid && rsp_rdata == 16'h0000, "R8 no-lane read", 32'({rsp_valid, rsp_rdata}), 32'h10000);
        chk(ce_cycles == ce_before, "R8 no chip select", 32'(ce_cycles - ce_before), 0);
        do_req(1'b0, 16'h0002, 16'h0, 2'b11, rd);
        chk(rd == 16'hA1B2, "R8 contents kept", 32'(rd), 32'hA1B2);

        // R6: no cycle with both drivers on
        chk(contention == 0, "R6 contention", 32'(contention), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule